// File: doc/BRIEF.md
# Grouped-Priority Nested Interrupt Controller

The block collects up to 32 interrupt sources. It keeps an enable bit, a pending bit, an active bit and a 4-bit priority for every source, and it tells a processor core which source to serve next. A grouping field, which software can change at run time, splits each priority into two parts. The upper part is a preemption level, and only that level can interrupt a handler that is already running. The lower part is a subpriority, which only orders requests that wait at the same time. A lower number always means a more urgent source.

Software reaches the block through a word-addressed register bus. Enable and pending state are changed through separate write-1-to-set and write-1-to-clear words. A trigger word sets the pending bit of the source number written to it. The core side is a combinational request (`take_req`, `take_id`) that the core accepts with `take_ack`. It ends each handler with `eoi_pulse`. A nesting stack remembers the order in which sources were taken, so that end-of-interrupt retires the most recent one.

The nesting tracker is a two-state machine. `ST_IDLE` means no source is active. `ST_NESTED` means at least one handler is running. The transition `IDLE->NESTED` happens on an accepted take. `NESTED->IDLE` happens on an end-of-interrupt that pops the last stack entry. `NESTED->NESTED` covers a further take (the stack grows) and an end-of-interrupt while more than one entry remains (the stack shrinks).

Top module: `gpic_top`

## Requirements
- R1: After reset, enable, pending and active read 0, every priority reads 0, the grouping field reads 0, and `take_req` is 0.
- R2: Word address 0x000 sets enables (write 1 to a bit to enable that source). Word 0x020 clears enables (write 1 to disable). Writing 0 changes nothing, and both words read back the current enable vector with bit n for source n.
- R3: Word 0x040 sets pending bits and word 0x060 clears them, both as write-1 operations. Both words read back the pending vector.
- R4: A 0-to-1 change on `irq_in[n]` sets pending bit n once. A level that stays high does not set the bit again after it is cleared.
- R5: Writing a value v below the source count to word 0x380 sets pending bit v.
- R6: The priority of source n is held in word 0x0C0 + n/4, byte n%4, bits [7:4] of that byte. Bits [3:0] of each byte read 0, and writes to them are ignored.
- R7: The grouping field is bits [10:8] of word 0x343. The number of preemption bits is 4 for field values 0 to 3, 3 for 4, 2 for 5, 1 for 6 and 0 for 7. The preemption level is the upper part of the priority selected by that count.
- R8: Sources that are pending, enabled and not active are candidates. `take_id` is the candidate with the lowest priority value, and the lowest source number breaks a full tie.
- R9: `take_req` is 1 only if a candidate exists and either nothing is active or the candidate's preemption level is strictly lower than the lowest preemption level among active sources. An equal level never preempts.
- R10: `take_ack` with `take_req` high clears that source's pending bit and sets its active bit at the next clock edge. Active bits read at word 0x080.
- R11: `eoi_pulse` clears the active bit of the most recently taken source that is still active. It has no effect when nothing is active. If it arrives in the same cycle as `take_ack`, the acknowledge is ignored.
- R12: If a pending bit is set and cleared in the same cycle, the set wins.
- R13: Word 0x080 is read-only, and writes to it change no active bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_in | input | 32 | Hardware interrupt levels, one bit per source |
| take_req | output | 1 | A source may be taken now |
| take_id | output | 5 | Number of the selected source |
| take_ack | input | 1 | Core accepts the current request |
| eoi_pulse | input | 1 | End of the most recent handler |

## Verification
The bench checks that an equal preemption level leaves a running handler alone. A design that compared with less-or-equal would nest a source onto itself. It also moves the grouping field to 7 and back while a handler is active. Here a controller that ignored the field would keep requesting when no preemption bits remain. Further tests cover a full priority tie, where a wrong design picks the higher source number, and an end-of-interrupt in the same cycle as an acknowledge, where a wrong design loses a handler or activates a source early. The bench also sends an end-of-interrupt with nothing active. Last, it collides a hardware rising edge with a clear-pending write, where a wrong design drops the new interrupt, and it holds a level high after clearing the bit, where a wrong design would re-raise it.

// File: rtl/gpic_pkg.sv
package gpic_pkg;

    localparam int PRIO_W = 4;
    localparam int LVL_W  = PRIO_W + 1;
    localparam int ADDR_W = 10;

    localparam logic [ADDR_W-1:0] A_SETEN  = 10'h000;
    localparam logic [ADDR_W-1:0] A_CLREN  = 10'h020;
    localparam logic [ADDR_W-1:0] A_SETPD  = 10'h040;
    localparam logic [ADDR_W-1:0] A_CLRPD  = 10'h060;
    localparam logic [ADDR_W-1:0] A_ACTIVE = 10'h080;
    localparam logic [ADDR_W-1:0] A_PRIO   = 10'h0C0;
    localparam logic [ADDR_W-1:0] A_CTRL   = 10'h343;
    localparam logic [ADDR_W-1:0] A_SWTRIG = 10'h380;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_NESTED = 1'b1
    } nest_state_t;

    // number of preemption bits selected by the grouping field
    function automatic logic [2:0] pre_bits(input logic [2:0] grp);
        logic [2:0] r;
        case (grp)
            3'd7:    r = 3'd0;
            3'd6:    r = 3'd1;
            3'd5:    r = 3'd2;
            3'd4:    r = 3'd3;
            default: r = 3'(PRIO_W);
        endcase
        return r;
    endfunction

    function automatic logic [LVL_W-1:0] pre_level(input logic [PRIO_W-1:0] p,
                                                   input logic [2:0] grp);
        logic [2:0] sh;
        sh = 3'(PRIO_W) - pre_bits(grp);
        return LVL_W'({1'b0, p} >> sh);
    endfunction

endpackage

// File: rtl/gpic_regs.sv
module gpic_regs
    import gpic_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_we,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [31:0]                       bus_wdata,
    output logic [31:0]                       bus_rdata,
    input  logic [NUM_SRC-1:0]                irq_in,
    input  logic [NUM_SRC-1:0]                take_clr,
    input  logic [NUM_SRC-1:0]                active,
    output logic [NUM_SRC-1:0]                en_q,
    output logic [NUM_SRC-1:0]                pend_q,
    output logic [NUM_SRC-1:0][PRIO_W-1:0]    prio_q,
    output logic [2:0]                        grp_q
);

    localparam int PRIO_WORDS = (NUM_SRC + 3) / 4;
    localparam int ID_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_SRC-1:0] irq_d;
    logic [NUM_SRC-1:0] wbits;
    logic [NUM_SRC-1:0] sw_set;
    logic [NUM_SRC-1:0] pend_set;
    logic [NUM_SRC-1:0] pend_clr;
    logic               wr_seten, wr_clren, wr_setpd, wr_clrpd, wr_ctrl, wr_trig;

    assign wbits    = bus_wdata[NUM_SRC-1:0];
    assign wr_seten = bus_we && (bus_addr == A_SETEN);
    assign wr_clren = bus_we && (bus_addr == A_CLREN);
    assign wr_setpd = bus_we && (bus_addr == A_SETPD);
    assign wr_clrpd = bus_we && (bus_addr == A_CLRPD);
    assign wr_ctrl  = bus_we && (bus_addr == A_CTRL);
    assign wr_trig  = bus_we && (bus_addr == A_SWTRIG);

    always_comb begin
        sw_set = '0;
        if (wr_trig && (bus_wdata < 32'(NUM_SRC)))
            sw_set[bus_wdata[ID_W-1:0]] = 1'b1;
    end

    assign pend_set = (irq_in & ~irq_d) | sw_set | (wr_setpd ? wbits : '0);
    assign pend_clr = take_clr | (wr_clrpd ? wbits : '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_d  <= '0;
            en_q   <= '0;
            pend_q <= '0;
            grp_q  <= '0;
            prio_q <= '0;
        end else begin
            irq_d  <= irq_in;
            en_q   <= (en_q & ~(wr_clren ? wbits : '0)) | (wr_seten ? wbits : '0);
            pend_q <= (pend_q & ~pend_clr) | pend_set;
            if (wr_ctrl)
                grp_q <= bus_wdata[10:8];
            for (int n = 0; n < NUM_SRC; n++) begin
                if (bus_we && (bus_addr == A_PRIO + ADDR_W'(n / 4)))
                    prio_q[n] <= bus_wdata[(n % 4) * 8 + 4 +: PRIO_W];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_SETEN, A_CLREN: bus_rdata = 32'(en_q);
            A_SETPD, A_CLRPD: bus_rdata = 32'(pend_q);
            A_ACTIVE:         bus_rdata = 32'(active);
            A_CTRL:           bus_rdata = {21'd0, grp_q, 8'd0};
            default: begin
                for (int w = 0; w < PRIO_WORDS; w++) begin
                    if (bus_addr == A_PRIO + ADDR_W'(w)) begin
                        for (int k = 0; k < 4; k++) begin
                            if (w * 4 + k < NUM_SRC)
                                bus_rdata[k * 8 + 4 +: PRIO_W] = prio_q[w * 4 + k];
                        end
                    end
                end
            end
        endcase
    end

    AST_PRIO_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr >= A_PRIO) && (bus_addr < A_PRIO + ADDR_W'(PRIO_WORDS)))
        |-> ((bus_rdata & 32'h0F0F_0F0F) == 32'd0)); // R6

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend_set) |=> ((pend_q & $past(pend_set)) == $past(pend_set))); // R12

endmodule

// File: rtl/gpic_arbiter.sv
module gpic_arbiter
    import gpic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int ID_W    = 5
) (
    input  logic [NUM_SRC-1:0]             en,
    input  logic [NUM_SRC-1:0]             pend,
    input  logic [NUM_SRC-1:0]             active,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    input  logic [2:0]                     grp,
    input  logic                           full,
    output logic                           take_req,
    output logic [ID_W-1:0]                take_id
);

    localparam logic [LVL_W-1:0] LVL_NONE = LVL_W'(1 << PRIO_W);

    logic [NUM_SRC-1:0] cand;
    logic               found;
    logic [PRIO_W-1:0]  best_p;
    logic [LVL_W-1:0]   cur_lvl;

    assign cand = pend & en & ~active;

    // best candidate: lowest priority value, lowest number on ties
    always_comb begin
        found   = 1'b0;
        best_p  = '0;
        take_id = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (cand[i] && (!found || (prio[i] < best_p))) begin
                found   = 1'b1;
                best_p  = prio[i];
                take_id = ID_W'(i);
            end
        end
    end

    // running preemption level: best level among active sources
    always_comb begin
        cur_lvl = LVL_NONE;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (active[i] && (pre_level(prio[i], grp) < cur_lvl))
                cur_lvl = pre_level(prio[i], grp);
        end
    end

    assign take_req = found && !full && (pre_level(best_p, grp) < cur_lvl);

endmodule

// File: rtl/gpic_nest.sv
module gpic_nest
    import gpic_pkg::*;
#(
    parameter int NUM_SRC    = 32,
    parameter int ID_W       = 5,
    parameter int NEST_DEPTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [ID_W-1:0]    push_id,
    input  logic               eoi,
    output logic [NUM_SRC-1:0] active_q,
    output logic               full,
    output logic               busy
);

    localparam int SP_W  = $clog2(NEST_DEPTH + 1);
    localparam int IDX_W = (NEST_DEPTH > 1) ? $clog2(NEST_DEPTH) : 1;

    nest_state_t       state_q, state_d;
    logic [ID_W-1:0]   stack_q [NEST_DEPTH];
    logic [SP_W-1:0]   sp_q;
    logic              pop, do_push;
    logic [IDX_W-1:0]  top_idx, wr_idx;

    assign pop     = eoi && (state_q == ST_NESTED);
    assign do_push = push && !eoi && !full;
    assign top_idx = IDX_W'(sp_q - 1'b1);
    assign wr_idx  = IDX_W'(sp_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (do_push) state_d = ST_NESTED;
            ST_NESTED: if (pop && (sp_q == SP_W'(1))) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q     <= '0;
            active_q <= '0;
            for (int d = 0; d < NEST_DEPTH; d++) stack_q[d] <= '0;
        end else if (pop) begin
            active_q[stack_q[top_idx]] <= 1'b0;
            sp_q                       <= sp_q - 1'b1;
        end else if (do_push) begin
            stack_q[wr_idx]   <= push_id;
            active_q[push_id] <= 1'b1;
            sp_q              <= sp_q + 1'b1;
        end
    end

    always_comb begin
        full = (sp_q == SP_W'(NEST_DEPTH));
        busy = (state_q == ST_NESTED);
    end

    AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (active_q == '0)); // R11

    AST_EOI_POPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && (state_q == ST_NESTED)) |=> ($countones(active_q) == $countones($past(active_q)) - 1)); // R11

endmodule

// File: rtl/gpic_top.sv
module gpic_top
    import gpic_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        bus_we,
    input  logic [9:0]                                  bus_addr,
    input  logic [31:0]                                 bus_wdata,
    output logic [31:0]                                 bus_rdata,
    input  logic [NUM_SRC-1:0]                          irq_in,
    output logic                                        take_req,
    output logic [((NUM_SRC > 1) ? $clog2(NUM_SRC) : 1)-1:0] take_id,
    input  logic                                        take_ack,
    input  logic                                        eoi_pulse
);

    localparam int ID_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int NEST_DEPTH = 1 << PRIO_W;

    logic [NUM_SRC-1:0]             en, pend, active, take_clr;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
    logic [2:0]                     grp;
    logic                           full, busy, take_fire;

    assign take_fire = take_ack && take_req && !eoi_pulse;

    always_comb begin
        take_clr = '0;
        if (take_fire) take_clr[take_id] = 1'b1;
    end

    gpic_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_in    (irq_in),
        .take_clr  (take_clr),
        .active    (active),
        .en_q      (en),
        .pend_q    (pend),
        .prio_q    (prio),
        .grp_q     (grp)
    );

    gpic_arbiter #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_arb (
        .en       (en),
        .pend     (pend),
        .active   (active),
        .prio     (prio),
        .grp      (grp),
        .full     (full),
        .take_req (take_req),
        .take_id  (take_id)
    );

    gpic_nest #(.NUM_SRC(NUM_SRC), .ID_W(ID_W), .NEST_DEPTH(NEST_DEPTH)) u_nest (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (take_fire),
        .push_id  (take_id),
        .eoi      (eoi_pulse),
        .active_q (active),
        .full     (full),
        .busy     (busy)
    );

    AST_TAKE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        take_req |-> (en[take_id] && pend[take_id] && !active[take_id])); // R8

    AST_ACK_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
        take_fire |=> (active[$past(take_id)] && busy)); // R10

endmodule

// File: tb/sim_gpic_top.sv
module sim_gpic_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_in = '0;
    logic        take_req;
    logic [4:0]  take_id;
    logic        take_ack = 1'b0;
    logic        eoi_pulse = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    gpic_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .take_req(take_req), .take_id(take_id), .take_ack(take_ack),
        .eoi_pulse(eoi_pulse)
    );

    // op: 0 write, 1 read with mask in data field, 2 take check {req,id}
    localparam int NV = 26;
    localparam logic [75:0] VEC [NV] = '{
        {2'd0, 10'h000, 32'h0000_00F0, 32'h0},          // R2
        {2'd1, 10'h000, 32'hFFFF_FFFF, 32'h0000_00F0},  // R2
        {2'd1, 10'h020, 32'hFFFF_FFFF, 32'h0000_00F0},  // R2
        {2'd0, 10'h020, 32'h0000_0030, 32'h0},          // R2
        {2'd1, 10'h000, 32'hFFFF_FFFF, 32'h0000_00C0},  // R2
        {2'd0, 10'h000, 32'h0000_0000, 32'h0},          // R2
        {2'd1, 10'h020, 32'hFFFF_FFFF, 32'h0000_00C0},  // R2
        {2'd0, 10'h040, 32'h0000_0105, 32'h0},          // R3
        {2'd1, 10'h040, 32'hFFFF_FFFF, 32'h0000_0105},  // R3
        {2'd1, 10'h060, 32'hFFFF_FFFF, 32'h0000_0105},  // R3
        {2'd0, 10'h060, 32'h0000_0004, 32'h0},          // R3
        {2'd1, 10'h040, 32'hFFFF_FFFF, 32'h0000_0101},  // R3
        {2'd0, 10'h380, 32'h0000_001F, 32'h0},          // R5
        {2'd1, 10'h040, 32'hFFFF_FFFF, 32'h8000_0101},  // R5
        {2'd0, 10'h0C1, 32'hFFFF_FFFF, 32'h0},          // R6
        {2'd1, 10'h0C1, 32'hFFFF_FFFF, 32'hF0F0_F0F0},  // R6
        {2'd0, 10'h080, 32'hFFFF_FFFF, 32'h0},          // R13
        {2'd1, 10'h080, 32'hFFFF_FFFF, 32'h0000_0000},  // R13
        {2'd0, 10'h343, 32'hFFFF_FFFF, 32'h0},          // R7
        {2'd1, 10'h343, 32'hFFFF_FFFF, 32'h0000_0700},  // R7
        {2'd2, 10'h000, 32'h0,         32'h0000_0000},  // R8 none enabled
        {2'd0, 10'h000, 32'h0000_0001, 32'h0},          // R8
        {2'd2, 10'h000, 32'h0,         32'h0000_0020},  // R8 src 0
        {2'd0, 10'h060, 32'hFFFF_FFFF, 32'h0},
        {2'd0, 10'h020, 32'hFFFF_FFFF, 32'h0},
        {2'd0, 10'h0C1, 32'h0000_0000, 32'h0}
    };

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [9:0] a, input logic [31:0] m,
                          input logic [31:0] e, input string req);
        bus_addr = a;
        #2;
        checks++;
        if ((bus_rdata & m) != e) begin
            fails++;
            $display("FAIL %s addr %h: got %h expected %h", req, a, bus_rdata & m, e);
        end
    endtask

    task automatic take_chk(input logic r, input logic [4:0] id, input string req);
        #2;
        checks++;
        if (take_req !== r || (r && take_id !== id)) begin
            fails++;
            $display("FAIL %s take: got req=%0d id=%0d expected req=%0d id=%0d",
                     req, take_req, take_id, r, id);
        end
    endtask

    task automatic pulse(input logic a, input logic e);
        @(negedge clk);
        take_ack = a; eoi_pulse = e;
        @(negedge clk);
        take_ack = 1'b0; eoi_pulse = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_chk(10'h000, 32'hFFFF_FFFF, 32'h0, "R1");
        rd_chk(10'h040, 32'hFFFF_FFFF, 32'h0, "R1");
        rd_chk(10'h080, 32'hFFFF_FFFF, 32'h0, "R1");
        rd_chk(10'h0C3, 32'hFFFF_FFFF, 32'h0, "R1");
        rd_chk(10'h343, 32'hFFFF_FFFF, 32'h0, "R1");
        take_chk(1'b0, 5'd0, "R1");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][75:74] == 2'd0) begin
                wr(VEC[i][73:64], VEC[i][63:32]);
            end else if (VEC[i][75:74] == 2'd1) begin
                @(negedge clk);
                rd_chk(VEC[i][73:64], VEC[i][63:32], VEC[i][31:0], "R2/R3/R5/R6/R7/R13 vector");
            end else begin
                @(negedge clk);
                take_chk(VEC[i][5], VEC[i][4:0], "R8 vector");
            end
        end
        wr(10'h343, 32'h0);

        // R8 selection and tie break
        wr(10'h000, 32'hFFFF_FFFF);
        wr(10'h0C0, 32'h5000_0000);   // src3 = 5
        wr(10'h0C1, 32'h5000_0000);   // src7 = 5
        wr(10'h0C2, 32'h0000_3000);   // src9 = 3
        wr(10'h0C3, 32'h0000_0020);   // src12 = 2
        wr(10'h040, 32'h0000_0088);
        take_chk(1'b1, 5'd3, "R8 tie");
        wr(10'h040, 32'h0000_0200);
        take_chk(1'b1, 5'd9, "R8 best");

        // R10 acknowledge
        pulse(1'b1, 1'b0);
        rd_chk(10'h080, 32'hFFFF_FFFF, 32'h0000_0200, "R10 active");
        rd_chk(10'h040, 32'h0000_0200, 32'h0, "R10 pending");
        take_chk(1'b0, 5'd0, "R9 no preempt");
        wr(10'h040, 32'h0000_1000);
        take_chk(1'b1, 5'd12, "R9 preempt");
        pulse(1'b1, 1'b0);
        rd_chk(10'h080, 32'hFFFF_FFFF, 32'h0000_1200, "R10 nested");
        take_chk(1'b0, 5'd0, "R9");

        // R11 end of interrupt ordering
        pulse(1'b0, 1'b1);
        rd_chk(10'h080, 32'hFFFF_FFFF, 32'h0000_0200, "R11 pop recent");
        take_chk(1'b0, 5'd0, "R9 equal level");
        pulse(1'b0, 1'b1);
        rd_chk(10'h080, 32'hFFFF_FFFF, 32'h0, "R11 pop last");
        take_chk(1'b1, 5'd3, "R9 idle");

        // R7 grouping
        wr(10'h343, 32'h0000_0500);
        pulse(1'b1, 1'b0);
        rd_chk(10'h080, 32'hFFFF_FFFF, 32'h0000_0008, "R10");
        take_chk(1'b0, 5'd0, "R7 same group level");
        wr(10'h040, 32'h0000_1000);
        take_chk(1'b1, 5'd12, "R7 level 0 beats 1");
        wr(10'h343, 32'h0000_0700);
        take_chk(1'b0, 5'd0, "R7 no preempt bits");
        wr(10'h343, 32'h0000_0500);
        take_chk(1'b1, 5'd12, "R7 restored");

        // R11 eoi together with ack
        pulse(1'b1, 1'b1);
        rd_chk(10'h080, 32'hFFFF_FFFF, 32'h0, "R11 ack ignored");
        rd_chk(10'h040, 32'h0000_1000, 32'h0000_1000, "R11 still pending");
        take_chk(1'b1, 5'd12, "R11");
        pulse(1'b0, 1'b1);
        rd_chk(10'h080, 32'hFFFF_FFFF, 32'h0, "R11 empty eoi");
        take_chk(1'b1, 5'd12, "R11 empty eoi");

        // R12 set beats clear, R4 edge only
        wr(10'h060, 32'hFFFF_FFFF);
        @(negedge clk);
        irq_in[1] = 1'b1;
        bus_we = 1'b1; bus_addr = 10'h060; bus_wdata = 32'h0000_0002;
        @(negedge clk);
        bus_we = 1'b0;
        rd_chk(10'h040, 32'h0000_0002, 32'h0000_0002, "R12");
        wr(10'h060, 32'h0000_0002);
        @(negedge clk);
        rd_chk(10'h040, 32'h0000_0002, 32'h0, "R4 level held");
        irq_in[1] = 1'b0;
        @(negedge clk);
        irq_in[1] = 1'b1;
        @(negedge clk);
        rd_chk(10'h040, 32'h0000_0002, 32'h0000_0002, "R4 new edge");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule